// File: doc/BRIEF.md
# Sticky Exception Flag Accumulator

This block keeps the sticky floating-point exception flags of a processor status word. Several floating-point units can report flag updates in the same cycle. Each unit supplies a valid strobe and a seven-bit flag vector. A unit whose operation was suppressed by a false guard simply leaves its valid strobe low. In the cycle the producing unit writes its destination register, the block merges every valid update into the held flags. The result is the OR of all incoming vectors and the current value, so a set flag stays set.

Software is the only agent that can clear flags. It does this through an explicit write port, which also loads the rounding-mode field of the status word. The block carries that field through unchanged and does not interpret it. If a software write and hardware updates arrive in the same cycle, the written value is taken first and the updates are ORed on top of it. The read port shows the registered state, so it does not yet include updates presented in the current cycle.

Top module: `sticky_flags_top`

## Requirements
- R1: After reset, the flag output and the rounding-mode output are both zero.
- R2: If an update port has its valid strobe high, every bit set in its vector is set on the flag output from the next clock edge onward.
- R3: An update port whose valid strobe is low has no effect on the flags, whatever its vector holds.
- R4: When several ports are valid in the same cycle, the next flag value is the bitwise OR of all valid vectors and the current flag value.
- R5: Without a software write, no flag ever changes from 1 to 0.
- R6: A software write with no valid updates in that cycle loads the written flag vector exactly, so it can clear flags.
- R7: A software write in the same cycle as valid updates yields the written vector ORed with all the valid update vectors.
- R8: The rounding-mode output changes only on a software write, where it takes the written value. Flag updates never alter it.
- R9: The flag output in a cycle reflects only updates from earlier cycles, never those presented in the same cycle.
- R10: Flag bit positions: bit 0 invalid operation, bit 1 overflow, bit 2 underflow, bit 3 inexact, bit 4 divide by zero, bit 5 input flushed to zero, bit 6 output flushed to zero. Each bit is merged independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| updValid | input | NUM_UPD (4) | Per-port update strobe |
| updFlags | input | NUM_UPD*7 (28) | Packed flag vectors; port k occupies bits 7k+6..7k |
| swWrEn | input | 1 | Software status-word write strobe |
| swWrFlags | input | 7 | Flag value for a software write |
| swWrRound | input | ROUND_W (2) | Rounding-mode value for a software write |
| rdFlags | output | 7 | Held sticky flags |
| rdRound | output | ROUND_W (2) | Held rounding-mode field |

## Verification
The bound checker verifies three properties on every cycle. First, flags never fall without a write. Second, each next-state value equals the prior flags, or the written vector, ORed with the valid updates. Third, the rounding field is held between writes. The reset values, the same-cycle invisibility of updates on the read port, and the per-bit independence across the named flag positions can only be shown by the bench's directed scenarios. The bench also runs a long randomized run that checks the merge against a behavioural model.

// File: rtl/sticky_flags_pkg.sv
package sticky_flags_pkg;
  localparam int FLAG_W = 7;
  localparam int BIT_INVALID = 0;
  localparam int BIT_OVERFLOW = 1;
  localparam int BIT_UNDERFLOW = 2;
  localparam int BIT_INEXACT = 3;
  localparam int BIT_DIVZERO = 4;
  localparam int BIT_INFLUSH = 5;
  localparam int BIT_OUTFLUSH = 6;

  typedef logic [FLAG_W-1:0] flagVec_t;

  typedef struct packed {
    logic     loadSw;
    flagVec_t mergeVec;
  } flagStrobe_t;
endpackage

// File: rtl/sticky_flags_ctrl.sv
module sticky_flags_ctrl
  import sticky_flags_pkg::*;
#(
  parameter int NUM_UPD = 4
) (
  input  logic [NUM_UPD-1:0]        updValid,
  input  logic [NUM_UPD*FLAG_W-1:0] updFlags,
  input  logic                      swWrEn,
  output flagStrobe_t               strobe
);
  flagVec_t maskedVec [NUM_UPD];

  for (genvar k = 0; k < NUM_UPD; k++) begin : gMask
    assign maskedVec[k] = updFlags[k*FLAG_W +: FLAG_W] & {FLAG_W{updValid[k]}};
  end

  always_comb begin
    flagVec_t acc;
    acc = '0;
    for (int k = 0; k < NUM_UPD; k++) begin
      acc = acc | maskedVec[k];
    end
    strobe.mergeVec = acc;
    strobe.loadSw   = swWrEn;
  end
endmodule

// File: rtl/sticky_flags_dp.sv
module sticky_flags_dp
  import sticky_flags_pkg::*;
#(
  parameter int ROUND_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  flagStrobe_t        strobe,
  input  flagVec_t           swWrFlags,
  input  logic [ROUND_W-1:0] swWrRound,
  output flagVec_t           heldFlags,
  output logic [ROUND_W-1:0] heldRound
);
  flagVec_t baseVec;

  assign baseVec = strobe.loadSw ? swWrFlags : heldFlags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      heldFlags <= '0;
      heldRound <= '0;
    end else begin
      heldFlags <= baseVec | strobe.mergeVec;
      if (strobe.loadSw) begin
        heldRound <= swWrRound;
      end
    end
  end
endmodule

// File: rtl/sticky_flags_top.sv
module sticky_flags_top
  import sticky_flags_pkg::*;
#(
  parameter int NUM_UPD = 4,
  parameter int ROUND_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_UPD-1:0]        updValid,
  input  logic [NUM_UPD*FLAG_W-1:0] updFlags,
  input  logic                      swWrEn,
  input  logic [FLAG_W-1:0]         swWrFlags,
  input  logic [ROUND_W-1:0]        swWrRound,
  output logic [FLAG_W-1:0]         rdFlags,
  output logic [ROUND_W-1:0]        rdRound
);
  flagStrobe_t strobe;

  sticky_flags_ctrl #(.NUM_UPD(NUM_UPD)) ctrl_i (
    .updValid (updValid),
    .updFlags (updFlags),
    .swWrEn   (swWrEn),
    .strobe   (strobe)
  );

  sticky_flags_dp #(.ROUND_W(ROUND_W)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .swWrFlags (swWrFlags),
    .swWrRound (swWrRound),
    .heldFlags (rdFlags),
    .heldRound (rdRound)
  );
endmodule

// File: rtl/sticky_flags_chk.sv
module sticky_flags_chk
  import sticky_flags_pkg::*;
#(
  parameter int NUM_UPD = 4,
  parameter int ROUND_W = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_UPD-1:0]        updValid,
  input logic [NUM_UPD*FLAG_W-1:0] updFlags,
  input logic                      swWrEn,
  input logic [FLAG_W-1:0]         swWrFlags,
  input logic [ROUND_W-1:0]        swWrRound,
  input logic [FLAG_W-1:0]         rdFlags,
  input logic [ROUND_W-1:0]        rdRound
);
  logic [FLAG_W-1:0] seenUpd;

  always_comb begin
    seenUpd = '0;
    for (int k = 0; k < NUM_UPD; k++) begin
      if (updValid[k]) seenUpd = seenUpd | updFlags[k*FLAG_W +: FLAG_W];
    end
  end

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !swWrEn |=> ((rdFlags & $past(rdFlags)) == $past(rdFlags))); // R5

  AST_UPDATE_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    !swWrEn |=> (rdFlags == ($past(rdFlags) | $past(seenUpd)))); // R4

  AST_UPDATE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rdFlags & $past(seenUpd)) == $past(seenUpd))); // R2

  AST_WRITE_THEN_OR: assert property (@(posedge clk) disable iff (!rst_n)
    swWrEn |=> (rdFlags == ($past(swWrFlags) | $past(seenUpd)))); // R7

  AST_ROUND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !swWrEn |=> $stable(rdRound)); // R8

  AST_ROUND_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    swWrEn |=> (rdRound == $past(swWrRound))); // R8
endmodule

bind sticky_flags_top sticky_flags_chk #(.NUM_UPD(NUM_UPD), .ROUND_W(ROUND_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .updValid  (updValid),
  .updFlags  (updFlags),
  .swWrEn    (swWrEn),
  .swWrFlags (swWrFlags),
  .swWrRound (swWrRound),
  .rdFlags   (rdFlags),
  .rdRound   (rdRound)
);

// File: tb/sticky_flags_top_tb_top.sv
module sticky_flags_top_tb_top;
  localparam int NU = 4;
  localparam int FW = 7;
  localparam int RW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NU-1:0] updValid = '0;
  logic [NU*FW-1:0] updFlags = '0;
  logic swWrEn = 1'b0;
  logic [FW-1:0] swWrFlags = '0;
  logic [RW-1:0] swWrRound = '0;
  logic [FW-1:0] rdFlags;
  logic [RW-1:0] rdRound;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  int modelFlags = 0;
  int modelRound = 0;

  always #10 clk = ~clk;

  sticky_flags_top dut_i (
    .clk(clk), .rst_n(rst_n), .updValid(updValid), .updFlags(updFlags),
    .swWrEn(swWrEn), .swWrFlags(swWrFlags), .swWrRound(swWrRound),
    .rdFlags(rdFlags), .rdRound(rdRound)
  );

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic stepCycle(string req, logic [NU-1:0] v, logic [NU*FW-1:0] f,
                           logic wr, int wf, int wrnd);
    int nxt;
    updValid = v; updFlags = f; swWrEn = wr;
    swWrFlags = FW'(wf); swWrRound = RW'(wrnd);
    #1;
    check("R9", int'(rdFlags), modelFlags);
    @(posedge clk);
    nxt = wr ? wf : modelFlags;
    for (int k = 0; k < NU; k++) begin
      if (v[k]) nxt = nxt | int'(f[k*FW +: FW]);
    end
    modelFlags = nxt;
    if (wr) modelRound = wrnd;
    @(negedge clk);
    check(req, int'(rdFlags), modelFlags);
    check("R8", int'(rdRound), modelRound);
  endtask

  function automatic logic [NU*FW-1:0] pack4(int a, int b, int c, int d);
    return {FW'(d), FW'(c), FW'(b), FW'(a)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(rdFlags), 0);
    check("R1", int'(rdRound), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(rdFlags), 0);
    // R2: overflow (bit1) and inexact (bit3) on port 2
    stepCycle("R2", 4'b0100, pack4(0, 0, 'h0A, 0), 0, 0, 0);
    // R3: invalid strobes with all-ones vectors
    stepCycle("R3", 4'b0000, pack4('h7F, 'h7F, 'h7F, 'h7F), 0, 0, 0);
    // R4: several ports together
    stepCycle("R4", 4'b1011, pack4('h01, 'h10, 'h7F, 'h40), 0, 0, 0);
    // R5: idle cycles keep flags
    stepCycle("R5", 4'b0000, '0, 0, 0, 0);
    stepCycle("R5", 4'b0000, '0, 0, 0, 0);
    // R6: write clears and loads
    stepCycle("R6", 4'b0000, pack4('h7F, 0, 0, 0), 1, 'h04, 2);
    stepCycle("R6", 4'b0000, '0, 1, 'h00, 3);
    // R7: write plus same-cycle updates
    stepCycle("R7", 4'b0011, pack4('h20, 'h01, 0, 0), 1, 'h08, 1);
    // R8: updates leave rounding untouched
    stepCycle("R8", 4'b1111, pack4('h02, 'h04, 'h10, 'h40), 0, 'h7F, 0);
    // R10: each named bit merged on its own
    stepCycle("R10", 4'b0000, '0, 1, 0, 0);
    for (int b = 0; b < FW; b++) begin
      stepCycle("R10", 4'b0001 << (b % NU), pack4(1 << b, 1 << b, 1 << b, 1 << b), 0, 0, 0);
      check("R10", int'(rdFlags[b]), 1);
    end
    // R4: randomized mix
    for (int i = 0; i < 300; i++) begin
      stepCycle("R4", NU'($urandom), (NU*FW)'({$urandom, $urandom}),
                ($urandom % 8) == 0, int'($urandom % 128), int'($urandom % 4));
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule